// File: doc/BRIEF.md
# Strobe-Driven Serial Character Retimer

This block sits behind a tone demodulator whose output is a single asynchronous bit stream at 1200 baud. It finds the start bit of each character, and samples the eight data bits at the middle of each bit period into a shift register. It then offers the finished character to a host one bit at a time on a single serial output pin. The host does not need a UART. It waits for the active-low interrupt, reads the pin, and pulses the strobe input to step to the next bit.

When no character is being read out, the serial output carries the demodulator stream unchanged, apart from a two-clock synchronizer delay. The host chooses between retimed and raw operation with the strobe level alone. If the strobe is low when a character completes, the character is held for readout. If the strobe is high at that moment, nothing is raised and the raw stream keeps flowing.

Both inputs pass through two-flop synchronizers. An internal tick runs at sixteen times the bit rate; its divider is a parameter. There is no back-pressure at either edge of the block. The line never waits, and the only flow control is the strobe handshake on the output pin. The host must finish a readout within one character time, about 8.3 ms.

Top module: `strobe_char_retimer`

## Requirements
- R1: Out of reset `irq_n` is 1. Whenever no readout is active, `ser_out` equals `line_in` as it was two clocks earlier.
- R2: A falling edge of the synchronized line starts reception. The line is checked again at tick 8 after that edge. If the line is high there, the character is abandoned and no interrupt follows.
- R3: Data bit k (k = 0..7) is sampled at tick 8+16·(k+1) after the start edge. The first bit received is bit 0 of the character, and it is the first bit presented.
- R4: If the synchronized strobe is low when bit 7 is captured, the next clock drives `irq_n` to 0 and shows bit 0 on `ser_out`. With a tick of D clocks, this happens 4+136·D clocks after `line_in` falls.
- R5: During a readout, each falling edge of the synchronized strobe presents the next stored bit. The eighth falling edge ends the readout, and `ser_out` then returns to the raw stream.
- R6: `irq_n` returns to 1 on the first rising edge of the synchronized strobe after it was driven low.
- R7: If the synchronized strobe is high when bit 7 is captured, no interrupt is raised and `ser_out` stays on the raw stream.
- R8: The receiver re-arms only at the middle of the stop bit. A start edge that arrives while a readout is active is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Demodulated serial stream (1 = mark/idle) |
| strobe_in | input | 1 | Host bit strobe; its level at completion selects retiming |
| ser_out | output | 1 | Raw stream or the current stored bit |
| irq_n | output | 1 | Active-low character-ready interrupt |

## Verification
The bench compares both outputs against a cycle-level model on every clock, across several stimulus patterns.
- Characters 0x35, 0x00, 0xFF and 0xA5 are read out with the strobe low. They show whether the bit order is LSB first and whether sampling lands mid-bit: the all-zero and all-one patterns expose a stuck or shifted bit, and 0x35, whose last bit is 0, makes the return to the raw idle level visible.
- A short low glitch on the line separates a proper start-bit recheck from a receiver that accepts any edge.
- A character sent with the strobe high shows that the completion-time strobe level chooses between retimed and raw operation.
- A second character sent during an unread readout shows that the start lockout keeps the first character intact.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/scr_sync2.sv
module scr_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/scr_tick_gen.sv
module scr_tick_gen #(
  parameter int DIV = 13021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clear || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/scr_char_rx.sv
module scr_char_rx
  import scr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_s,
  input  logic                 line_fall,
  input  logic                 hold,
  output logic                 tick_clr,
  output logic                 idle,
  output logic                 done,
  output logic [DATA_BITS-1:0] data
);
  localparam int SW = $clog2(OVS);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [SW-1:0] MID     = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] SUB_TOP = SW'(OVS - 1);
  localparam logic [BW-1:0] LAST    = BW'(DATA_BITS - 1);

  rx_state_e state_q;
  logic [SW-1:0] sub_q;
  logic [BW-1:0] bit_q;
  logic          mid;

  assign idle     = (state_q == RX_IDLE);
  assign tick_clr = idle;
  assign mid      = tick && (sub_q == MID) && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (idle) begin
      sub_q <= '0;
    end else if (tick) begin
      sub_q <= (sub_q == SUB_TOP) ? '0 : sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      done    <= 1'b0;
      data    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (line_fall && !hold) begin
            state_q <= RX_START;
            bit_q   <= '0;
          end
        end
        RX_START: begin
          if (mid) begin
            state_q <= line_s ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (mid) begin
            data <= {line_s, data[DATA_BITS-1:1]};
            if (bit_q == LAST) begin
              state_q <= RX_STOP;
              done    <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (mid) begin
            state_q <= RX_IDLE;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scr_readout.sv
module scr_readout #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 strobe_s,
  input  logic                 strobe_rise,
  input  logic                 strobe_fall,
  input  logic                 line_s,
  output logic                 active,
  output logic                 irq_n,
  output logic                 ser_out
);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BW-1:0] LAST = BW'(DATA_BITS - 1);

  logic [DATA_BITS-1:0] out_sh;
  logic [BW-1:0]        cnt_q;

  assign ser_out = active ? out_sh[0] : line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      irq_n  <= 1'b1;
      out_sh <= '0;
      cnt_q  <= '0;
    end else if (done && !strobe_s) begin
      active <= 1'b1;
      irq_n  <= 1'b0;
      out_sh <= data;
      cnt_q  <= '0;
    end else if (active) begin
      if (strobe_rise) begin
        irq_n <= 1'b1;
      end
      if (strobe_fall) begin
        if (cnt_q == LAST) begin
          active <= 1'b0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          out_sh <= out_sh >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/strobe_char_retimer.sv
module strobe_char_retimer #(
  parameter int TICK_DIV  = 13021,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic strobe_in,
  output logic ser_out,
  output logic irq_n
);
  logic                 line_s, strobe_s;
  logic                 line_q, strobe_q;
  logic                 line_fall, strobe_rise, strobe_fall;
  logic                 tick, tick_clr;
  logic                 rx_idle, char_done, ro_active;
  logic [DATA_BITS-1:0] char_data;

  scr_sync2 #(.W(1), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  scr_sync2 #(.W(1), .RST_VAL(1'b0)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_in), .q(strobe_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      line_q   <= line_s;
      strobe_q <= strobe_s;
    end
  end

  assign line_fall   = line_q && !line_s;
  assign strobe_rise = strobe_s && !strobe_q;
  assign strobe_fall = !strobe_s && strobe_q;

  scr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(tick_clr), .tick(tick)
  );

  scr_char_rx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(line_s),
    .line_fall(line_fall), .hold(ro_active), .tick_clr(tick_clr),
    .idle(rx_idle), .done(char_done), .data(char_data)
  );

  scr_readout #(.DATA_BITS(DATA_BITS)) u_ro (
    .clk(clk), .rst_n(rst_n), .done(char_done), .data(char_data),
    .strobe_s(strobe_s), .strobe_rise(strobe_rise), .strobe_fall(strobe_fall),
    .line_s(line_s), .active(ro_active), .irq_n(irq_n), .ser_out(ser_out)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker (
  input logic clk,
  input logic rst_n,
  input logic line_in,
  input logic ser_out,
  input logic irq_n,
  input logic strobe_s,
  input logic strobe_q,
  input logic ro_active,
  input logic rx_idle,
  input logic char_done
);
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 1'b1;
  end

  // R1: raw passthrough with two-clock latency when no readout runs
  p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2 && !ro_active) |-> (ser_out == $past(line_in, 2)));

  // R4 / R7: interrupt only follows a completion seen with the strobe low
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(char_done) && !$past(strobe_s)));

  // R4: an asserted interrupt always belongs to a live readout
  p_irq_in_readout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ro_active);

  // R5: a readout only ends on a strobe falling edge
  p_end_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ro_active) |-> ($past(strobe_q) && !$past(strobe_s)));

  // R6: first strobe rise releases the interrupt
  p_irq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_s && !strobe_q && ro_active && !irq_n) |=> irq_n);

  // R8: receiver stays idle while a readout is active
  p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_active && rx_idle) |=> rx_idle);
endmodule

bind strobe_char_retimer scr_checker u_scr_checker (
  .clk(clk), .rst_n(rst_n), .line_in(line_in), .ser_out(ser_out),
  .irq_n(irq_n), .strobe_s(strobe_s), .strobe_q(strobe_q),
  .ro_active(ro_active), .rx_idle(rx_idle), .char_done(char_done)
);

// File: tb/strobe_char_retimer_bench.sv
`timescale 1ns/1ps
module strobe_char_retimer_bench;
  localparam int D   = 2;
  localparam int BIT = 16 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic strobe_in = 1'b0;
  logic ser_out, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int irq_falls = 0;
  int irq_fall_cyc = 0;
  bit prev_irq = 1'b1;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  strobe_char_retimer #(.TICK_DIV(D), .OVS(16), .DATA_BITS(8)) u_strobe_char_retimer (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .strobe_in(strobe_in),
    .ser_out(ser_out), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: cycle counts measured from the detected start edge
  bit m_l1 = 1, m_l2 = 1, m_lp = 1, m_s1 = 0, m_s2 = 0, m_sp = 0;
  bit m_busy = 0, m_done = 0, m_act = 0, m_irq = 1;
  bit [7:0] m_cap = 0, m_buf = 0;
  int m_t = 0, m_idx = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_l1 = 1; m_l2 = 1; m_lp = 1; m_s1 = 0; m_s2 = 0; m_sp = 0;
      m_busy = 0; m_done = 0; m_act = 0; m_irq = 1; m_t = 0; m_idx = 0;
    end else begin
      bit dn;
      dn = 0;
      if (!m_busy) begin
        if (m_lp && !m_l2 && !m_act) begin m_busy = 1; m_t = 0; end
      end else begin
        m_t++;
        if (m_t == 8 * D) begin
          if (m_l2) m_busy = 0;
        end else if (m_t > 8 * D && (m_t - 8 * D) % BIT == 0) begin
          int k;
          k = (m_t - 8 * D) / BIT - 1;
          if (k < 8) begin
            m_cap[k] = m_l2;
            if (k == 7) dn = 1;
          end else m_busy = 0;
        end
      end
      if (m_done && !m_s2) begin
        m_act = 1; m_irq = 0; m_buf = m_cap; m_idx = 0;
      end else if (m_act) begin
        if (m_s2 && !m_sp) m_irq = 1;
        if (!m_s2 && m_sp) begin
          if (m_idx == 7) m_act = 0; else m_idx++;
        end
      end
      m_done = dn;
      m_lp = m_l2; m_l2 = m_l1; m_l1 = line_in;
      m_sp = m_s2; m_s2 = m_s1; m_s1 = strobe_in;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(ser_out == (m_act ? m_buf[m_idx] : m_l2), "R5 model ser_out",
          ser_out, m_act ? m_buf[m_idx] : m_l2);
      chk(irq_n == m_irq, "R6 model irq_n", irq_n, m_irq);
    end
    if (prev_irq && !irq_n) begin irq_falls++; irq_fall_cyc = cyc; end
    prev_irq = irq_n;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input bit [7:0] b, output int t0);
    @(negedge clk);
    line_in = 1'b0; t0 = cyc;
    idle(BIT);
    for (int i = 0; i < 8; i++) begin line_in = b[i]; idle(BIT); end
    line_in = 1'b1; idle(BIT);
  endtask

  task automatic read_char(output bit [7:0] got);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      got[i] = ser_out;
      strobe_in = 1'b1; idle(3);
      if (i == 0) chk(irq_n == 1'b1, "R6 irq released by first strobe", irq_n, 1);
      strobe_in = 1'b0; idle(3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int t0, fc;
    bit [7:0] got;
    idle(3);
    chk(irq_n == 1'b1, "R1 reset irq_n", irq_n, 1);
    chk(ser_out == 1'b1, "R1 reset ser_out", ser_out, 1);
    rst_n = 1'b1;
    model_on = 1'b1;
    idle(4);

    // R2: short glitch must not start a character
    fc = irq_falls;
    line_in = 1'b0; idle(1);
    chk(ser_out == 1'b1, "R1 passthrough lag", ser_out, 1);
    idle(1);
    chk(ser_out == 1'b0, "R1 passthrough after two clocks", ser_out, 0);
    idle(4); line_in = 1'b1;
    idle(12 * BIT);
    chk(irq_falls == fc, "R2 false start ignored", irq_falls - fc, 0);

    // R3 R4 R5 R6: strobe low at completion, LSB-first readout
    send_frame(8'h35, t0);
    chk(irq_fall_cyc - t0 == 4 + 136 * D, "R4 interrupt latency", irq_fall_cyc - t0, 4 + 136 * D);
    chk(ser_out == 1'b1, "R4 bit0 on ser_out", ser_out, 1);
    read_char(got);
    chk(got == 8'h35, "R3 byte 0x35", got, 8'h35);
    chk(ser_out == 1'b1, "R5 raw stream after eighth strobe", ser_out, 1);

    send_frame(8'h00, t0); read_char(got);
    chk(got == 8'h00, "R3 byte 0x00", got, 0);
    send_frame(8'hFF, t0); read_char(got);
    chk(got == 8'hFF, "R3 byte 0xFF", got, 8'hFF);

    // R7: strobe high at completion
    strobe_in = 1'b1; idle(4);
    fc = irq_falls;
    send_frame(8'h3C, t0); idle(2 * BIT);
    chk(irq_falls == fc, "R7 no interrupt with strobe high", irq_falls - fc, 0);
    chk(irq_n == 1'b1, "R7 irq_n stays high", irq_n, 1);
    strobe_in = 1'b0; idle(4);

    // R8: second character during unread readout is ignored
    fc = irq_falls;
    send_frame(8'hA5, t0);
    send_frame(8'h0F, t0);
    chk(irq_falls == fc + 1, "R8 single interrupt", irq_falls - fc, 1);
    read_char(got);
    chk(got == 8'hA5, "R8 first character kept", got, 8'hA5);
    idle(12 * BIT);
    chk(irq_falls == fc + 1, "R8 locked-out frame never delivered", irq_falls - fc, 1);
    chk(irq_n == 1'b1, "R8 idle afterwards", irq_n, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule